// File: doc/BRIEF.md
# Message Length Fail-Safe Timer

This block guards a serial bus transmitter against a stuck or runaway message. It watches a one-bit indication that the transmitter is driving the line and counts how many clocks of activity the current transmission has used. Idle stretches that are short enough are treated as part of the same transmission. When the count passes the allowed message length, a sticky fail-safe flag rises and a kill output forces both differential transmit lines low.

The flag stays set until one of two things happens. The first is a one-cycle pulse reporting that a valid command word carrying this terminal's own address has been received. The second is a master reset input that is held low for a minimum time. A master reset pulse that is shorter than the minimum has no effect. A master reset only clears the flag. It does not clear the elapsed length, so a transmission that resumes after a short reset gap is still over the limit, and the flag rises again.

The parameter defaults assume a 12 MHz clock. The length limit is 768 µs, which is 9216 clocks. The continuity gap is 3 µs, which is 36 clocks. The minimum reset width is 1 µs, which is 12 clocks.

Top module: `tx_length_guard`

## Requirements
- R1: The length count advances by one on each clock edge at which `tx_active` is 1. The count saturates at LIMIT_CYC+1. `fail_safe` rises at the edge after the count reaches LIMIT_CYC+1 (the count must strictly exceed LIMIT_CYC). It stays low at every earlier edge.
- R2: `tx_kill` is high exactly when `fail_safe` is high.
- R3: Once set, `fail_safe` stays high through any amount of transmit idle time. Only the two clear events of R6 and R7 (or `rst_n`) lower it.
- R4: A run of at most GAP_CYC consecutive idle edges (`tx_active` = 0) leaves the length count unchanged. When activity resumes, counting continues from the held value.
- R5: The idle edge numbered GAP_CYC+1 in a run clears the length count to zero.
- R6: An `own_cmd_hit` pulse clears `fail_safe` and the length count at that edge. The pulse takes priority over a flag set that would otherwise occur at the same edge.
- R7: Let `mrst_n` be low for MRST_MIN_CYC consecutive edges. `fail_safe` then clears at the next edge and stays low for as long as `mrst_n` remains low. A low pulse of MRST_MIN_CYC-1 edges has no effect on the flag.
- R8: A master reset clear does not change the length count. If the count is still past the limit when `mrst_n` returns high, `fail_safe` rises again one edge after the clearing edge.
- R9: While `rst_n` is low, `fail_safe` and `tx_kill` are 0 and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tx_active | input | 1 | 1 while the transmitter is driving the bus |
| own_cmd_hit | input | 1 | One-cycle pulse: valid command with own address received |
| mrst_n | input | 1 | Master reset request, active low, width-qualified |
| fail_safe | output | 1 | Sticky over-length flag |
| tx_kill | output | 1 | Forces both transmit lines low when high |

## Verification
The stimulus mixes uninterrupted transmissions with transmissions that contain idle gaps of exactly the allowed width and of one clock more. Comparing these shows whether elapsed length is carried across a short gap or restarted after a long one. Master reset pulses of one clock below the minimum width and of exactly the minimum width separate a width-qualified clear from an edge-triggered one. A reset given while the count is still past the limit shows that only the flag is cleared and the count is kept. An address-match pulse is placed on the very edge where the flag would otherwise set, which exposes the priority between clearing and setting.

// File: rtl/tx_length_guard.sv
module tx_length_guard #(
  parameter int LIMIT_CYC    = 9216,
  parameter int GAP_CYC      = 36,
  parameter int MRST_MIN_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic own_cmd_hit,
  input  logic mrst_n,
  output logic fail_safe,
  output logic tx_kill
);

  localparam int LEN_W = $clog2(LIMIT_CYC + 2);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int RST_W = $clog2(MRST_MIN_CYC + 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(LIMIT_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC);
  localparam logic [RST_W-1:0] RST_FULL = RST_W'(MRST_MIN_CYC);

  logic [LEN_W-1:0] len_cnt;
  logic [GAP_W-1:0] idle_cnt;
  logic [RST_W-1:0] low_cnt;
  logic             mrst_clr;

  assign mrst_clr = (low_cnt == RST_FULL);
  assign tx_kill  = fail_safe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idle_cnt <= '0;
    else if (tx_active)          idle_cnt <= '0;
    else if (idle_cnt != GAP_LAST) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  len_cnt <= '0;
    else if (own_cmd_hit)        len_cnt <= '0;
    else if (tx_active) begin
      if (len_cnt != LEN_MAX)    len_cnt <= len_cnt + 1'b1;
    end
    else if (idle_cnt == GAP_LAST) len_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_cnt <= '0;
    else if (mrst_n)             low_cnt <= '0;
    else if (low_cnt != RST_FULL) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fail_safe <= 1'b0;
    else if (own_cmd_hit || mrst_clr) fail_safe <= 1'b0;
    else if (len_cnt == LEN_MAX)      fail_safe <= 1'b1;
  end

  // R1
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_safe) |-> $past(len_cnt) == LEN_MAX);

  // R3
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_safe && !own_cmd_hit && !mrst_clr) |=> fail_safe);

  // R4
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !own_cmd_hit && idle_cnt != GAP_LAST) |=> $stable(len_cnt));

  // R5
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !own_cmd_hit && idle_cnt == GAP_LAST) |=> len_cnt == '0);

  // R6
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_cmd_hit |=> (!fail_safe && len_cnt == '0));

  // R7
  mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst_n && low_cnt == RST_FULL - 1'b1) |=> ##1 !fail_safe);

  // R8
  mrst_keeps_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst_clr && !own_cmd_hit && !tx_active && idle_cnt != GAP_LAST) |=> $stable(len_cnt));

endmodule

// File: tb/tx_length_guard_tb_top.sv
`timescale 1ns/100ps
module tx_length_guard_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic own_cmd_hit = 1'b0;
  logic mrst_n = 1'b1;
  logic fail_safe, tx_kill;
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  tx_length_guard dut_i (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .own_cmd_hit(own_cmd_hit), .mrst_n(mrst_n),
    .fail_safe(fail_safe), .tx_kill(tx_kill)
  );

  // {act, mrst_n, hit, edges[15:0], expected flag, req[3:0]}
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,16'd100,  1'b0,4'd1},  // R1 start counting
    {1'b0,1'b1,1'b0,16'd36,   1'b0,4'd4},  // R4 gap of exactly 36 holds
    {1'b1,1'b1,1'b0,16'd9117, 1'b0,4'd4},  // R4 count now 9217, no flag yet
    {1'b1,1'b1,1'b0,16'd1,    1'b1,4'd1},  // R1 flag rises
    {1'b0,1'b1,1'b0,16'd200,  1'b1,4'd3},  // R3 sticky through idle
    {1'b0,1'b1,1'b1,16'd1,    1'b0,4'd6},  // R6 own command clears
    {1'b1,1'b1,1'b0,16'd9217, 1'b0,4'd5},  // R5 count restarted from zero
    {1'b1,1'b1,1'b0,16'd1,    1'b1,4'd1},  // R1
    {1'b1,1'b0,1'b0,16'd11,   1'b1,4'd7},  // R7 reset 11 edges
    {1'b1,1'b1,1'b0,16'd1,    1'b1,4'd7},  // R7 short pulse ignored
    {1'b0,1'b0,1'b0,16'd12,   1'b1,4'd7},  // R7 12 low edges, not yet
    {1'b0,1'b0,1'b0,16'd1,    1'b0,4'd7},  // R7 cleared
    {1'b0,1'b1,1'b0,16'd1,    1'b0,4'd7},  // R7 still clear at release edge
    {1'b0,1'b1,1'b0,16'd1,    1'b1,4'd8},  // R8 length kept, flag back
    {1'b0,1'b0,1'b0,16'd13,   1'b0,4'd7},  // R7 clear again
    {1'b0,1'b0,1'b0,16'd20,   1'b0,4'd5},  // R5 long gap drops count
    {1'b0,1'b1,1'b0,16'd5,    1'b0,4'd8},  // R8 no re-set after long gap
    {1'b1,1'b1,1'b0,16'd9217, 1'b0,4'd1},  // R1
    {1'b1,1'b1,1'b1,16'd1,    1'b0,4'd6},  // R6 hit beats set
    {1'b1,1'b1,1'b0,16'd9217, 1'b0,4'd6},  // R6 count restarted
    {1'b1,1'b1,1'b0,16'd1,    1'b1,4'd1}   // R1
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(fail_safe, 1'b0, "R9");
    check(tx_kill, 1'b0, "R9");
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_active   = VEC[i][23];
      mrst_n      = VEC[i][22];
      own_cmd_hit = VEC[i][21];
      repeat (int'(VEC[i][20:5])) @(posedge clk);
      #1;
      check(fail_safe, VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
      check(tx_kill, VEC[i][4], "R2");
    end
    @(negedge clk);
    own_cmd_hit = 1'b0;
    rst_n = 1'b0;
    #1;
    check(fail_safe, 1'b0, "R9");
    check(tx_kill, 1'b0, "R2");
    @(negedge clk) rst_n = 1'b1;
    repeat (50) @(posedge clk);
    #1;
    check(fail_safe, 1'b0, "R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule